// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block is the master side of an SPI controller. It takes transmit words from a valid/ready handshake and turns each one into serial clock, data-out and chip-select activity on four select pins. It captures the incoming serial line into a received word. Each word carries a four-bit select code. The sequencer picks one of four per-select settings from that code: clock divider, word length, clock polarity, clock phase, setup delay and inter-word delay. A single prescale flag multiplies every delay by 32.

The select pins run in one of two ways. In priority 1-of-4 form the lowest zero bit of the code pulls one pin low. In decode form the code appears on the pins as a binary value for an external 4-to-16 decoder. Three delays shape the bus timing:
- a setup delay from select assertion to the first clock edge;
- a gap after every word while the select stays low;
- a release gap before a different select is asserted, which has a hardware minimum.

A word marked last drops its select on the final clock transition. A loopback input feeds data-out back into the receiver in place of the input line.

Top module: `spi_xfer_seq`

## Requirements
- R1: Each word shifts out bits [L-1:0] of txData MSB first, where L = cfgBitsM8 + 8 (8 to 16) and bits above L-1 are ignored. SPCK makes exactly 2L transitions per word. rxValid pulses for one cycle with the L captured bits, right-aligned and zero above, in rxData.
- R2: Each SPCK half period lasts the selected slot's divider in clocks, and a divider of 0 behaves as 1. Slot s uses cfgDiv[8s+7:8s], cfgBitsM8[4s+3:4s], cfgCpol[s], cfgCpha[s], cfgDlyBs[8s+7:8s] and cfgDlyBct[8s+7:8s].
- R3: SPCK rests at the slot's polarity bit when the select asserts. With phase 0, data-out changes only on trailing (even-numbered) transitions. With phase 1, it changes only on leading (odd-numbered) transitions, and the sample is taken on the other edge.
- R4: The first SPCK transition comes D*N + div clocks after the select goes low. D is the setup delay, N is 32 when fdiv is 1 and 1 otherwise, and div is the effective divider. A setup delay of 0 gives 2*div.
- R5: With decodeMode 0, the lowest zero bit k of the code drives npcs[k] low and leaves the other pins high (code 0101 gives 1101), and slot k is used.
- R6: With decodeMode 1, npcs equals the code while selected, and slot code[3:2] is used.
- R7: Code 1111 is accepted and discarded. No select asserts and no word is received.
- R8: A word with txLast set releases npcs to 1111 in the same cycle as its final SPCK transition.
- R9: A word without txLast keeps the select low. A following word to the same code starts its first transition T+1+div clocks after the previous word's last one, with T = 32*N*dlyBct (0 adds nothing).
- R10: Between releasing one select and asserting the next, npcs stays 1111 for L+1 clocks, with L = max(dlyBcs,6)*N. A word to a different code first releases the held select.
- R11: With loopback 0 the receiver samples miso; with loopback 1 it samples its own mosi.
- R12: SPCK does not change while npcs has been 1111 for two consecutive cycles.
- R13: After reset npcs is 1111, spck is 0, rxValid is 0 and txReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Word accepted on this clock edge |
| txData | input | 16 | Transmit data, right-aligned |
| txPcs | input | 4 | Select code of the word |
| txLast | input | 1 | Release the select after this word |
| cfgDiv | input | 32 | Four 8-bit half-period dividers |
| cfgBitsM8 | input | 16 | Four 4-bit word lengths minus 8 |
| cfgCpol | input | 4 | Clock polarity per slot |
| cfgCpha | input | 4 | Clock phase per slot |
| cfgDlyBs | input | 32 | Four 8-bit setup delays |
| cfgDlyBct | input | 32 | Four 8-bit inter-word delays |
| fdiv | input | 1 | Multiply all delays by 32 |
| dlyBcs | input | 8 | Release gap between selects |
| decodeMode | input | 1 | 0: priority 1-of-4, 1: binary code on pins |
| loopback | input | 1 | Receive from mosi instead of miso |
| miso | input | 1 | Serial data in |
| spck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| npcs | output | 4 | Active-low select pins |
| rxValid | output | 1 | Received word strobe |
| rxData | output | 16 | Received word |

## Verification
A countdown loaded with the wrong value moves the first clock edge, the gap between words or the select release gap by a whole number of clocks. That error shows within one word at the pins. A wrong slot choice or a wrong pin decode shows in the select pattern or the clock period from the very first transition. A shifter that steps on the wrong edge corrupts the looped-back word, and that shows at the next rxValid pulse. A sequencer that leaves its hold state by mistake releases the select early, or never releases it, and the release timing shows this after the final transition.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int DATA_W = 16;
  localparam int PCS_W  = 4;
  localparam int BLEN_W = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SHIFT, S_WORDGAP, S_HOLD, S_CSGAP
  } seq_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // take a new word
    logic csOn;      // assert the select
    logic csOff;     // release the select
    logic edgeT;     // toggle the serial clock
    logic shiftOut;  // advance the transmit shifter
    logic sampleIn;  // capture one receive bit
    logic done;      // word complete
  } seq_strobe_t;

  function automatic logic [1:0] pcsSlot(input logic [PCS_W-1:0] pcs, input logic dec);
    if (dec)          return pcs[3:2];
    else if (!pcs[0]) return 2'd0;
    else if (!pcs[1]) return 2'd1;
    else if (!pcs[2]) return 2'd2;
    else              return 2'd3;
  endfunction

  function automatic logic [PCS_W-1:0] pcsPins(input logic [PCS_W-1:0] pcs, input logic dec);
    if (dec) return pcs;
    return ~(4'b0001 << pcsSlot(pcs, 1'b0));
  endfunction
endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txValid,
  input  logic [PCS_W-1:0]  txPcs,
  input  logic              txLast,
  output logic              txReady,
  input  logic              fdiv,
  input  logic              decodeMode,
  input  logic [DLY_W-1:0]  dlyBcs,
  input  logic [DIV_W-1:0]  selDiv,
  input  logic [BLEN_W-1:0] selBitsM8,
  input  logic              selCpha,
  input  logic [DLY_W-1:0]  selDlyBs,
  input  logic [DLY_W-1:0]  selDlyBct,
  output logic [1:0]        cfgSlot,
  output logic [PCS_W-1:0]  curPcs,
  output seq_strobe_t       stb
);
  localparam logic [DLY_W-1:0] MIN_BCS = DLY_W'(6);

  seq_state_t state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [4:0]       halfCnt, halfN;
  logic             curLast;

  function automatic logic [CNT_W-1:0] units(input logic [DLY_W-1:0] v, input logic f);
    return f ? (CNT_W'(v) << 5) : CNT_W'(v);
  endfunction

  logic [DIV_W-1:0] effDiv;
  logic [CNT_W-1:0] divLoad, setupLoad, bctLoad, bcsLoad;
  logic [4:0]       lastHalf;
  logic             isLead, finalHalf;

  assign effDiv    = (selDiv == '0) ? DIV_W'(1) : selDiv;
  assign divLoad   = CNT_W'(effDiv) - CNT_W'(1);
  assign setupLoad = (selDlyBs == '0) ? divLoad : units(selDlyBs, fdiv) - CNT_W'(1);
  assign bctLoad   = (fdiv ? (CNT_W'(selDlyBct) << 10) : (CNT_W'(selDlyBct) << 5)) - CNT_W'(1);
  assign bcsLoad   = units((dlyBcs < MIN_BCS) ? MIN_BCS : dlyBcs, fdiv) - CNT_W'(1);
  assign lastHalf  = ((5'(selBitsM8) + 5'd8) << 1) - 5'd1;
  assign isLead    = ~halfCnt[0];
  assign finalHalf = (halfCnt == lastHalf);
  assign cfgSlot   = pcsSlot((state == S_IDLE) ? txPcs : curPcs, decodeMode);

  always_comb begin
    stb     = '0;
    txReady = 1'b0;
    stateN  = state;
    cntN    = cnt;
    halfN   = halfCnt;
    case (state)
      S_IDLE: begin
        txReady = 1'b1;
        if (txValid && txPcs != 4'hF) begin
          stb.load = 1'b1;
          stb.csOn = 1'b1;
          cntN     = setupLoad;
          stateN   = S_SETUP;
        end
      end
      S_SETUP: begin
        if (cnt == '0) begin
          cntN   = divLoad;
          halfN  = '0;
          stateN = S_SHIFT;
        end else cntN = cnt - CNT_W'(1);
      end
      S_SHIFT: begin
        if (cnt != '0) cntN = cnt - CNT_W'(1);
        else begin
          stb.edgeT    = 1'b1;
          cntN         = divLoad;
          halfN        = halfCnt + 5'd1;
          stb.sampleIn = selCpha ? !isLead : isLead;
          stb.shiftOut = selCpha ? (isLead && halfCnt != '0) : (!isLead && !finalHalf);
          if (finalHalf) begin
            stb.done = 1'b1;
            if (curLast) begin
              stb.csOff = 1'b1;
              cntN      = bcsLoad;
              stateN    = S_CSGAP;
            end else if (selDlyBct != '0) begin
              cntN   = bctLoad;
              stateN = S_WORDGAP;
            end else stateN = S_HOLD;
          end
        end
      end
      S_WORDGAP: begin
        if (cnt == '0) stateN = S_HOLD;
        else cntN = cnt - CNT_W'(1);
      end
      S_HOLD: begin
        if (txValid) begin
          if (txPcs == curPcs) begin
            txReady  = 1'b1;
            stb.load = 1'b1;
            cntN     = divLoad;
            halfN    = '0;
            stateN   = S_SHIFT;
          end else begin
            stb.csOff = 1'b1;
            cntN      = bcsLoad;
            stateN    = S_CSGAP;
          end
        end
      end
      S_CSGAP: begin
        if (cnt == '0) stateN = S_IDLE;
        else cntN = cnt - CNT_W'(1);
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      halfCnt <= '0;
      curPcs  <= 4'hF;
      curLast <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      halfCnt <= halfN;
      if (stb.load) begin
        curPcs  <= txPcs;
        curLast <= txLast;
      end
    end
  end
endmodule

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       stb,
  input  logic [DATA_W-1:0] txData,
  input  logic [PCS_W-1:0]  curPcs,
  input  logic [BLEN_W-1:0] selBitsM8,
  input  logic              selCpol,
  input  logic              decodeMode,
  input  logic              loopback,
  input  logic              miso,
  output logic              spck,
  output logic              mosi,
  output logic [PCS_W-1:0]  npcs,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txSh, rxSh, rxNext, mask;
  logic [DATA_W:0]   maskFull;
  logic              csActive, inBit;
  logic [3:0]        topBit;

  assign topBit   = selBitsM8 + 4'd7;
  assign mosi     = txSh[topBit];
  assign inBit    = loopback ? mosi : miso;
  assign rxNext   = stb.sampleIn ? {rxSh[DATA_W-2:0], inBit} : rxSh;
  assign maskFull = ((DATA_W+1)'(1) << (5'(selBitsM8) + 5'd8)) - (DATA_W+1)'(1);
  assign mask     = maskFull[DATA_W-1:0];
  assign npcs     = csActive ? pcsPins(curPcs, decodeMode) : 4'hF;

  always_ff @(posedge clk) begin
    if (rst) begin
      txSh     <= '0;
      rxSh     <= '0;
      spck     <= 1'b0;
      csActive <= 1'b0;
      rxValid  <= 1'b0;
      rxData   <= '0;
    end else begin
      rxValid <= stb.done;
      if (stb.load) begin
        txSh <= txData;
        rxSh <= '0;
      end else begin
        if (stb.shiftOut) txSh <= txSh << 1;
        rxSh <= rxNext;
      end
      if (stb.csOn) spck <= selCpol;
      else if (stb.edgeT) spck <= ~spck;
      if (stb.csOn) csActive <= 1'b1;
      else if (stb.csOff) csActive <= 1'b0;
      if (stb.done) rxData <= rxNext & mask;
    end
  end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txValid,
  output logic              txReady,
  input  logic [15:0]       txData,
  input  logic [3:0]        txPcs,
  input  logic              txLast,
  input  logic [4*DIV_W-1:0] cfgDiv,
  input  logic [15:0]       cfgBitsM8,
  input  logic [3:0]        cfgCpol,
  input  logic [3:0]        cfgCpha,
  input  logic [4*DLY_W-1:0] cfgDlyBs,
  input  logic [4*DLY_W-1:0] cfgDlyBct,
  input  logic              fdiv,
  input  logic [DLY_W-1:0]  dlyBcs,
  input  logic              decodeMode,
  input  logic              loopback,
  input  logic              miso,
  output logic              spck,
  output logic              mosi,
  output logic [3:0]        npcs,
  output logic              rxValid,
  output logic [15:0]       rxData
);
  seq_strobe_t       stb;
  logic [1:0]        cfgSlot;
  logic [PCS_W-1:0]  curPcs;
  logic [DIV_W-1:0]  selDiv;
  logic [BLEN_W-1:0] selBitsM8;
  logic [DLY_W-1:0]  selDlyBs, selDlyBct;
  logic              selCpol, selCpha;

  assign selDiv    = cfgDiv[cfgSlot*DIV_W +: DIV_W];
  assign selBitsM8 = cfgBitsM8[cfgSlot*BLEN_W +: BLEN_W];
  assign selDlyBs  = cfgDlyBs[cfgSlot*DLY_W +: DLY_W];
  assign selDlyBct = cfgDlyBct[cfgSlot*DLY_W +: DLY_W];
  assign selCpol   = cfgCpol[cfgSlot];
  assign selCpha   = cfgCpha[cfgSlot];

  spi_seq_ctrl #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rst(rst), .txValid(txValid), .txPcs(txPcs), .txLast(txLast),
    .txReady(txReady), .fdiv(fdiv), .decodeMode(decodeMode), .dlyBcs(dlyBcs),
    .selDiv(selDiv), .selBitsM8(selBitsM8), .selCpha(selCpha),
    .selDlyBs(selDlyBs), .selDlyBct(selDlyBct), .cfgSlot(cfgSlot),
    .curPcs(curPcs), .stb(stb)
  );

  spi_seq_dp dp (
    .clk(clk), .rst(rst), .stb(stb), .txData(txData), .curPcs(curPcs),
    .selBitsM8(selBitsM8), .selCpol(selCpol), .decodeMode(decodeMode),
    .loopback(loopback), .miso(miso), .spck(spck), .mosi(mosi),
    .npcs(npcs), .rxValid(rxValid), .rxData(rxData)
  );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       txValid,
  input logic       txReady,
  input logic [3:0] txPcs,
  input logic       decodeMode,
  input logic [3:0] npcs,
  input logic       spck,
  input logic       rxValid
);
  assert_rx_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_onehot_pins_R5: assert property (@(posedge clk) disable iff (rst)
    !decodeMode |-> ($countones(~npcs) <= 1));

  assert_reserved_code_R7: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady && txPcs == 4'hF && npcs == 4'hF) |=> (npcs == 4'hF));

  assert_select_follows_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady && txPcs != 4'hF && npcs == 4'hF) |=> (npcs != 4'hF));

  assert_quiet_clock_R12: assert property (@(posedge clk) disable iff (rst)
    (npcs == 4'hF && $past(npcs) == 4'hF) |-> $stable(spck));
endmodule

bind spi_xfer_seq spi_seq_chk chkInst (
  .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady), .txPcs(txPcs),
  .decodeMode(decodeMode), .npcs(npcs), .spck(spck), .rxValid(rxValid)
);

// File: tb/spi_xfer_seq_test.sv
`timescale 1ns/1ps
module spi_xfer_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        txValid = 1'b0, txLast = 1'b0;
  logic [15:0] txData = '0;
  logic [3:0]  txPcs = 4'hF;
  logic [31:0] cfgDiv = '0, cfgDlyBs = '0, cfgDlyBct = '0;
  logic [15:0] cfgBitsM8 = '0;
  logic [3:0]  cfgCpol = '0, cfgCpha = '0;
  logic        fdiv = 1'b0, decodeMode = 1'b0, loopback = 1'b1, miso = 1'b0;
  logic [7:0]  dlyBcs = '0;
  logic        txReady, spck, mosi, rxValid;
  logic [3:0]  npcs;
  logic [15:0] rxData;

  spi_xfer_seq uut (
    .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady), .txData(txData),
    .txPcs(txPcs), .txLast(txLast), .cfgDiv(cfgDiv), .cfgBitsM8(cfgBitsM8),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgDlyBs(cfgDlyBs), .cfgDlyBct(cfgDlyBct),
    .fdiv(fdiv), .dlyBcs(dlyBcs), .decodeMode(decodeMode), .loopback(loopback),
    .miso(miso), .spck(spck), .mosi(mosi), .npcs(npcs), .rxValid(rxValid), .rxData(rxData)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // pin monitor, sampled between edges
  int cyc = 0, fallCyc = 0, riseCyc = 0, lastChg = 0, firstDelay = 0, csGap = 0;
  int edges = 0, minGap = 0, maxGap = 0, leadChg = 0, trailChg = 0;
  int fallCount = 0, rxCount = 0, idleChg = 0;
  logic [3:0]  sessNpcs = 4'hF, prevNpcs = 4'hF;
  logic        prevSpck = 1'b0, prevMosi = 1'b0, spckAtFall = 1'b0, gotFirst = 1'b0;
  logic [15:0] rxLast = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (npcs != 4'hF && prevNpcs == 4'hF) begin
        csGap = cyc - riseCyc; fallCyc = cyc; sessNpcs = npcs; fallCount++;
        spckAtFall = spck; gotFirst = 0; edges = 0; minGap = 1000000; maxGap = 0;
        leadChg = 0; trailChg = 0;
      end
      if (npcs == 4'hF && prevNpcs != 4'hF) riseCyc = cyc;
      if (spck != prevSpck) begin
        if (prevNpcs != 4'hF) begin
          edges++;
          if (!gotFirst) begin firstDelay = cyc - fallCyc; gotFirst = 1; end
          else begin
            if (cyc - lastChg < minGap) minGap = cyc - lastChg;
            if (cyc - lastChg > maxGap) maxGap = cyc - lastChg;
          end
          lastChg = cyc;
          if (mosi != prevMosi) begin
            if (edges % 2 == 1) leadChg++; else trailChg++;
          end
        end else if (npcs == 4'hF) idleChg++;
      end
      if (rxValid) begin rxCount++; rxLast = rxData; end
    end
    prevNpcs = npcs; prevSpck = spck; prevMosi = mosi;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setSlot(input int s, input logic [7:0] d, input logic [3:0] b,
                         input logic p, input logic h, input logic [7:0] bs, input logic [7:0] bct);
    cfgDiv[s*8 +: 8] = d;  cfgBitsM8[s*4 +: 4] = b;
    cfgCpol[s] = p;        cfgCpha[s] = h;
    cfgDlyBs[s*8 +: 8] = bs; cfgDlyBct[s*8 +: 8] = bct;
  endtask

  task automatic cfgAll(input logic [7:0] d, input logic [3:0] b, input logic p,
                        input logic h, input logic [7:0] bs, input logic [7:0] bct);
    for (int s = 0; s < 4; s++) setSlot(s, d, b, p, h, bs, bct);
  endtask

  task automatic sendWord(input logic [15:0] d, input logic [3:0] p, input logic l);
    @(negedge clk);
    txData = d; txPcs = p; txLast = l; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitRx(input int target);
    int t = 0;
    while (rxCount < target && t < 5000) begin @(negedge clk); t++; end
    repeat (260) @(negedge clk);
  endtask

  typedef struct packed {
    logic        dec;
    logic [3:0]  pcs;
    logic [1:0]  slot;
    logic        cpol;
    logic        cpha;
    logic [3:0]  bm8;
    logic [7:0]  div;
    logic [15:0] data;
    logic [3:0]  pins;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 4'b1110, 2'd0, 1'b0, 1'b0, 4'd0, 8'd2, 16'hFFA5, 4'b1110},
    '{1'b0, 4'b0101, 2'd1, 1'b1, 1'b0, 4'd4, 8'd1, 16'h0ABC, 4'b1101},
    '{1'b0, 4'b1011, 2'd2, 1'b0, 1'b1, 4'd8, 8'd3, 16'hC3A5, 4'b1011},
    '{1'b0, 4'b0111, 2'd3, 1'b1, 1'b1, 4'd1, 8'd0, 16'hF1F3, 4'b0111},
    '{1'b1, 4'b1010, 2'd2, 1'b0, 1'b1, 4'd2, 8'd2, 16'h0155, 4'b1010},
    '{1'b1, 4'b0000, 2'd0, 1'b1, 1'b0, 4'd0, 8'd1, 16'h005A, 4'b0000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(npcs == 4'hF, "R13 npcs", npcs, 15);
    check(spck == 1'b0, "R13 spck", spck, 0);
    check(rxValid == 1'b0, "R13 rxValid", rxValid, 0);
    check(txReady == 1'b1, "R13 txReady", txReady, 1);

    for (int i = 0; i < 6; i++) begin
      vec_t v;
      int eff, bits, mask, r0;
      string pinReq;
      v = VECS[i];
      eff = (v.div == 0) ? 1 : int'(v.div);
      bits = int'(v.bm8) + 8;
      mask = (1 << bits) - 1;
      pinReq = v.dec ? "R6 pins" : "R5 pins";
      cfgAll(8'd7, 4'd3, ~v.cpol, ~v.cpha, 8'd0, 8'd0);
      setSlot(int'(v.slot), v.div, v.bm8, v.cpol, v.cpha, 8'd0, 8'd0);
      decodeMode = v.dec;
      r0 = rxCount;
      sendWord(v.data, v.pcs, 1'b1);
      waitRx(r0 + 1);
      check(int'(rxLast) == (int'(v.data) & mask), "R1 loopback word", rxLast, int'(v.data) & mask);
      check(sessNpcs == v.pins, pinReq, sessNpcs, v.pins);
      check(edges == 2 * bits, "R1 transitions", edges, 2 * bits);
      check(minGap == eff && maxGap == eff, "R2 half period", maxGap, eff);
      check(spckAtFall == v.cpol, "R3 idle polarity", spckAtFall, v.cpol);
      if (v.cpha) check(trailChg == 0 && leadChg > 0, "R3 phase1 launch", trailChg, 0);
      else        check(leadChg == 0 && trailChg > 0, "R3 phase0 launch", leadChg, 0);
      check(firstDelay == 2 * eff, "R4 zero setup", firstDelay, 2 * eff);
      check(riseCyc == lastChg, "R8 release", riseCyc - lastChg, 0);
    end
    decodeMode = 1'b0;

    // R4 setup delay, plain and prescaled
    cfgAll(8'd2, 4'd0, 1'b0, 1'b0, 8'd3, 8'd0);
    sendWord(16'h003C, 4'b1110, 1'b1); waitRx(rxCount + 1);
    check(firstDelay == 5, "R4 setup 3", firstDelay, 5);
    fdiv = 1'b1;
    cfgAll(8'd1, 4'd0, 1'b0, 1'b0, 8'd1, 8'd0);
    sendWord(16'h003C, 4'b1110, 1'b1); waitRx(rxCount + 1);
    check(firstDelay == 33, "R4 setup prescaled", firstDelay, 33);
    fdiv = 1'b0;

    // R9 inter-word gap with the select held
    begin
      int f0, r0;
      cfgAll(8'd2, 4'd0, 1'b0, 1'b0, 8'd0, 8'd1);
      f0 = fallCount; r0 = rxCount;
      sendWord(16'h0011, 4'b1110, 1'b0);
      sendWord(16'h0022, 4'b1110, 1'b1);
      waitRx(r0 + 2);
      check(fallCount == f0 + 1, "R9 select held", fallCount - f0, 1);
      check(maxGap == 35, "R9 word gap", maxGap, 35);
      check(rxCount == r0 + 2 && rxLast == 16'h0022, "R1 second word", rxLast, 16'h22);
      check(riseCyc == lastChg, "R8 release after pair", riseCyc - lastChg, 0);
      cfgAll(8'd2, 4'd0, 1'b0, 1'b0, 8'd0, 8'd0);
      r0 = rxCount;
      sendWord(16'h0033, 4'b1110, 1'b0);
      sendWord(16'h0044, 4'b1110, 1'b1);
      waitRx(r0 + 2);
      check(maxGap == 3, "R9 zero gap", maxGap, 3);
    end

    // R10 release gap between selects
    dlyBcs = 8'd2;
    sendWord(16'h0055, 4'b1110, 1'b0);
    sendWord(16'h0066, 4'b1101, 1'b1); waitRx(rxCount + 1);
    check(csGap == 7, "R10 minimum gap", csGap, 7);
    check(sessNpcs == 4'b1101, "R5 new select", sessNpcs, 13);
    dlyBcs = 8'd10;
    sendWord(16'h0077, 4'b1110, 1'b1);
    sendWord(16'h0088, 4'b1011, 1'b1); waitRx(rxCount + 1);
    check(csGap == 11, "R10 programmed gap", csGap, 11);
    fdiv = 1'b1; dlyBcs = 8'd0;
    cfgAll(8'd1, 4'd0, 1'b0, 1'b0, 8'd0, 8'd0);
    sendWord(16'h0099, 4'b1110, 1'b1);
    sendWord(16'h00AA, 4'b1101, 1'b1); waitRx(rxCount + 1);
    check(csGap == 193, "R10 prescaled gap", csGap, 193);
    fdiv = 1'b0;

    // R7 reserved code
    begin
      int f0, r0;
      f0 = fallCount; r0 = rxCount;
      sendWord(16'h1234, 4'hF, 1'b1);
      repeat (40) @(negedge clk);
      check(fallCount == f0, "R7 no select", fallCount - f0, 0);
      check(rxCount == r0, "R7 no word", rxCount - r0, 0);
    end

    // R11 external input line
    loopback = 1'b0; miso = 1'b1;
    cfgAll(8'd1, 4'd0, 1'b0, 1'b0, 8'd0, 8'd0);
    sendWord(16'h0000, 4'b1110, 1'b1); waitRx(rxCount + 1);
    check(rxLast == 16'h00FF, "R11 miso high", rxLast, 16'hFF);
    cfgAll(8'd1, 4'd4, 1'b0, 1'b1, 8'd0, 8'd0);
    sendWord(16'h0FFF, 4'b1110, 1'b1); waitRx(rxCount + 1);
    check(rxLast == 16'h0FFF, "R11 miso high 12 bits", rxLast, 16'hFFF);
    miso = 1'b0;
    sendWord(16'h0FFF, 4'b1110, 1'b1); waitRx(rxCount + 1);
    check(rxLast == 16'h0000, "R11 miso low", rxLast, 0);

    check(idleChg == 0, "R12 quiet clock", idleChg, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule